// File: doc/BRIEF.md
# Lane Deskew Release Controller

This controller sits on the receive side of a multi-lane serial link. Each lane parks its incoming octet words in an elastic buffer, and this block decides when all of those buffers are opened together. Aligned data then leaves every lane in the same cycle, and the latency through the link is deterministic. Each lane reports, with a one-cycle strobe, when it sees the alignment character that ends its alignment sequence. The controller waits until every enabled lane has reported. It then issues one common release pulse at a fixed point in the local multiframe.

The multiframe is counted in link cycles, and one link cycle carries four octets. By default the release point is the multiframe boundary. A programmable offset moves it earlier, in whole link cycles. Before release proceeds, the device-aligned output is expected to return, possibly after being combined with the flags of other devices, as an all-devices-aligned input.

The block raises a sticky deskew error flag in three cases:
- the lane arrivals are spread over too wide a window;
- the chosen offset would put the release point at or before the last lane arrival;
- misalignment is reported once user data is flowing.

A re-synchronisation strobe restarts arrival collection.

Top module: `lane_deskew_release`

## Requirements
- R1: After reset `rel_pulse`, `dev_aligned` and `deskew_err` are all 0.
- R2: `dev_aligned` rises in the cycle after the cycle in which the last enabled lane first strobes `a_arrive`. Strobes on lanes whose `lane_en` bit is 0 are ignored, and so are repeated strobes from a lane that has already arrived.
- R3: With `rel_ofs` = 0, `rel_pulse` is high for exactly the first cycle after arming in which `mf_bnd` is high (`mf_cnt` = 0).
- R4: With `rel_ofs` = k > 0, `rel_pulse` is high for exactly the first cycle after arming in which `mf_cnt` = `mf_len` − k. The pulse lasts one cycle and occurs at most once per alignment.
- R5: The alignment completes in a cycle whose counter value is c. If `rel_ofs` ≥ `mf_len` − c, no release is armed: `deskew_err` rises and `dev_aligned` stays 0 in the next cycle.
- R6: The arrival window opens at the first enabled-lane strobe, which counts as spread 0. Arrivals up to spread `mf_len` − 1 are legal. If a lane is still missing at spread `mf_len`, `deskew_err` is raised and nothing is armed.
- R7: Release happens only while `align_all_in` is 1. If that input is 0 at the release point, the block waits for the release point of the next multiframe.
- R8: After release, `realign_err` = 1 raises `deskew_err` and clears `dev_aligned` in the next cycle. Before release it has no effect.
- R9: `deskew_err` holds until `err_clr` is 1. An error event in the same cycle as `err_clr` leaves the flag set.
- R10: `resync` = 1 clears `dev_aligned` in the next cycle and restarts arrival collection. It leaves `deskew_err` unchanged.
- R11: After any deskew failure there is no release until `resync`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock, one link cycle of four octets per edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lane_en | input | LANES | Per-lane enable; disabled lanes are not waited for |
| a_arrive | input | LANES | Per-lane alignment-character arrival strobe |
| mf_cnt | input | MF_W | Link-cycle position inside the local multiframe |
| mf_bnd | input | 1 | High in the cycle where `mf_cnt` is 0 |
| mf_len | input | MF_W | Multiframe length in link cycles (≥ 1) |
| rel_ofs | input | MF_W | Early-release offset in link cycles |
| align_all_in | input | 1 | All-devices-aligned input that gates release |
| realign_err | input | 1 | Misalignment detected during user data |
| err_clr | input | 1 | Write-one-to-clear strobe for the error flag |
| resync | input | 1 | Restart arrival collection |
| rel_pulse | output | 1 | Common elastic-buffer release pulse |
| dev_aligned | output | 1 | All enabled lanes arrived and release is armed or done |
| deskew_err | output | 1 | Sticky deskew error flag |

## Verification
The bench drives the arrival window to spread `mf_len` − 1, where arming must still succeed, and to spread `mf_len`, where it must fail. A window counter that is off by one would either reject a legal lane set or accept one spread over a full multiframe.

For the offset it targets the last legal value and the first illegal one, where the release point would land on the arrival cycle. A wrong comparison would release in the same cycle as the final arrival, or refuse a release that is one cycle later.

It also checks the following:
- Disabled lanes, repeated strobes and a low all-devices-aligned input must neither arm early nor release early.
- A clear that lands together with a new error must lose.
- Re-synchronisation must not wipe the error flag.

// File: rtl/ldr_pkg.sv
package ldr_pkg;
  typedef enum logic [1:0] {
    PH_COLLECT = 2'd0,
    PH_ARMED   = 2'd1,
    PH_RUN     = 2'd2,
    PH_FAIL    = 2'd3
  } ldr_phase_e;
endpackage

// File: rtl/ldr_arrival_track.sv
// Collects first arrivals per enabled lane and times the arrival window.
module ldr_arrival_track #(
  parameter int unsigned LANES = 4,
  parameter int unsigned MF_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [LANES-1:0] lane_en,
  input  logic [LANES-1:0] a_arrive,
  input  logic [MF_W-1:0]  mf_len,
  output logic             all_in,
  output logic             spread_err
);
  logic [LANES-1:0] seen_q;
  logic [LANES-1:0] seen_nx;
  logic [LANES-1:0] hits;
  logic             win_q;
  logic [MF_W-1:0]  spread_q;

  genvar gi;
  generate
    for (gi = 0; gi < LANES; gi++) begin : g_lane
      assign hits[gi]    = a_arrive[gi] & lane_en[gi];
      assign seen_nx[gi] = seen_q[gi] | hits[gi];
      always_ff @(posedge clk) begin
        if (!rst_n || clr) seen_q[gi] <= 1'b0;
        else               seen_q[gi] <= seen_nx[gi];
      end
    end
  endgenerate

  // Spread of the current cycle relative to the first arrival.
  assign spread_err = win_q && (spread_q >= mf_len);
  assign all_in     = (|lane_en) && ((seen_nx & lane_en) == lane_en) && !spread_err;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      win_q    <= 1'b0;
      spread_q <= '0;
    end else if (!win_q) begin
      if (|hits) begin
        win_q    <= 1'b1;
        spread_q <= MF_W'(1);
      end
    end else if (spread_q != mf_len) begin
      spread_q <= spread_q + MF_W'(1);
    end
  end
endmodule

// File: rtl/ldr_release_gate.sv
// Release-point match and offset legality, kept as pure functions.
module ldr_release_gate #(
  parameter int unsigned MF_W = 8
) (
  input  logic [MF_W-1:0] mf_cnt,
  input  logic            mf_bnd,
  input  logic [MF_W-1:0] mf_len,
  input  logic [MF_W-1:0] rel_ofs,
  output logic            at_target,
  output logic            ofs_legal
);
  function automatic logic f_hit(input logic [MF_W-1:0] cnt, input logic bnd,
                                 input logic [MF_W-1:0] len, input logic [MF_W-1:0] ofs);
    if (ofs == '0) return bnd;
    return cnt == (len - ofs);
  endfunction

  // Release must fall strictly after the completing cycle within this multiframe.
  function automatic logic f_legal(input logic [MF_W-1:0] cnt, input logic [MF_W-1:0] len,
                                   input logic [MF_W-1:0] ofs);
    return ofs < (len - cnt);
  endfunction

  assign at_target = f_hit(mf_cnt, mf_bnd, mf_len, rel_ofs);
  assign ofs_legal = f_legal(mf_cnt, mf_len, rel_ofs);
endmodule

// File: rtl/ldr_sticky_flag.sv
// Sticky flag: set wins over write-one clear.
module ldr_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n)   q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end
endmodule

// File: rtl/lane_deskew_release.sv
module lane_deskew_release
  import ldr_pkg::*;
#(
  parameter int unsigned LANES = 4,
  parameter int unsigned MF_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] lane_en,
  input  logic [LANES-1:0] a_arrive,
  input  logic [MF_W-1:0]  mf_cnt,
  input  logic             mf_bnd,
  input  logic [MF_W-1:0]  mf_len,
  input  logic [MF_W-1:0]  rel_ofs,
  input  logic             align_all_in,
  input  logic             realign_err,
  input  logic             err_clr,
  input  logic             resync,
  output logic             rel_pulse,
  output logic             dev_aligned,
  output logic             deskew_err
);
  ldr_phase_e phase_q, phase_nx;

  logic collect_phase, armed_phase, run_phase, fail_phase;
  logic trk_clr, all_in, spread_err;
  logic at_target, ofs_legal;
  logic arm_ok, arm_bad, window_bad, run_misalign, release_now, err_evt;

  assign collect_phase = (phase_q == PH_COLLECT);
  assign armed_phase   = (phase_q == PH_ARMED);
  assign run_phase     = (phase_q == PH_RUN);
  assign fail_phase    = (phase_q == PH_FAIL);

  assign trk_clr = resync || !collect_phase;

  ldr_arrival_track #(.LANES(LANES), .MF_W(MF_W)) i_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (trk_clr),
    .lane_en    (lane_en),
    .a_arrive   (a_arrive),
    .mf_len     (mf_len),
    .all_in     (all_in),
    .spread_err (spread_err)
  );

  ldr_release_gate #(.MF_W(MF_W)) i_gate (
    .mf_cnt    (mf_cnt),
    .mf_bnd    (mf_bnd),
    .mf_len    (mf_len),
    .rel_ofs   (rel_ofs),
    .at_target (at_target),
    .ofs_legal (ofs_legal)
  );

  assign window_bad   = !resync && collect_phase && spread_err;
  assign arm_ok       = !resync && collect_phase && all_in && ofs_legal;
  assign arm_bad      = !resync && collect_phase && all_in && !ofs_legal;
  assign release_now  = !resync && armed_phase && at_target && align_all_in;
  assign run_misalign = !resync && run_phase && realign_err;
  assign err_evt      = window_bad || arm_bad || run_misalign;

  always_comb begin
    phase_nx = phase_q;
    if (resync) begin
      phase_nx = PH_COLLECT;
    end else begin
      case (phase_q)
        PH_COLLECT: if (window_bad || arm_bad) phase_nx = PH_FAIL;
                    else if (arm_ok)           phase_nx = PH_ARMED;
        PH_ARMED:   if (release_now)           phase_nx = PH_RUN;
        PH_RUN:     if (run_misalign)          phase_nx = PH_FAIL;
        default:    phase_nx = PH_FAIL;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) phase_q <= PH_COLLECT;
    else        phase_q <= phase_nx;
  end

  ldr_sticky_flag i_err (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (err_evt),
    .clr   (err_clr),
    .q     (deskew_err)
  );

  assign rel_pulse   = release_now;
  assign dev_aligned = armed_phase || run_phase;
endmodule

// File: rtl/ldr_chk.sv
module ldr_chk #(
  parameter int unsigned MF_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            rel_pulse,
  input logic            dev_aligned,
  input logic            deskew_err,
  input logic            align_all_in,
  input logic            err_clr,
  input logic            resync,
  input logic            realign_err,
  input logic            run_phase,
  input logic            fail_phase,
  input logic            err_evt,
  input logic [MF_W-1:0] mf_cnt,
  input logic            mf_bnd,
  input logic [MF_W-1:0] mf_len,
  input logic [MF_W-1:0] rel_ofs
);
  AST_REL_NEEDS_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    rel_pulse |-> (dev_aligned && align_all_in)); // R7
  AST_REL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rel_pulse |=> !rel_pulse); // R4
  AST_REL_ON_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    rel_pulse |-> ((rel_ofs == '0) ? mf_bnd : (mf_cnt == mf_len - rel_ofs))); // R3
  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (deskew_err && !err_clr) |=> deskew_err); // R9
  AST_ERR_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt |=> deskew_err); // R9
  AST_RUN_MISALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (run_phase && realign_err && !resync) |=> (deskew_err && !dev_aligned)); // R8
  AST_RESYNC_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    resync |=> !dev_aligned); // R10
  AST_FAIL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    fail_phase |-> !rel_pulse); // R11
endmodule

bind lane_deskew_release ldr_chk #(.MF_W(MF_W)) i_ldr_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rel_pulse    (rel_pulse),
  .dev_aligned  (dev_aligned),
  .deskew_err   (deskew_err),
  .align_all_in (align_all_in),
  .err_clr      (err_clr),
  .resync       (resync),
  .realign_err  (realign_err),
  .run_phase    (run_phase),
  .fail_phase   (fail_phase),
  .err_evt      (err_evt),
  .mf_cnt       (mf_cnt),
  .mf_bnd       (mf_bnd),
  .mf_len       (mf_len),
  .rel_ofs      (rel_ofs)
);

// File: tb/test_lane_deskew_release.sv
module test_lane_deskew_release;
  localparam int LANES = 4;
  localparam int MF_W  = 8;
  localparam int MFL   = 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [LANES-1:0] lane_en;
  logic [LANES-1:0] a_arrive;
  logic [MF_W-1:0]  mf_cnt;
  logic             mf_bnd;
  logic [MF_W-1:0]  mf_len;
  logic [MF_W-1:0]  rel_ofs;
  logic             align_all_in;
  logic             realign_err;
  logic             err_clr;
  logic             resync;
  logic             rel_pulse;
  logic             dev_aligned;
  logic             deskew_err;

  int n_vec = 0;
  int n_bad = 0;
  int mfc   = MFL - 1;

  always #2 clk = ~clk;

  lane_deskew_release #(.LANES(LANES), .MF_W(MF_W)) i_lane_deskew_release (
    .clk(clk), .rst_n(rst_n), .lane_en(lane_en), .a_arrive(a_arrive),
    .mf_cnt(mf_cnt), .mf_bnd(mf_bnd), .mf_len(mf_len), .rel_ofs(rel_ofs),
    .align_all_in(align_all_in), .realign_err(realign_err), .err_clr(err_clr),
    .resync(resync), .rel_pulse(rel_pulse), .dev_aligned(dev_aligned),
    .deskew_err(deskew_err)
  );

  task automatic check(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // Advance one link cycle: step the multiframe counter, drop strobes.
  task automatic tick();
    @(negedge clk);
    mfc         = (mfc == MFL - 1) ? 0 : mfc + 1;
    mf_cnt      = MF_W'(mfc);
    mf_bnd      = (mfc == 0);
    a_arrive    = '0;
    realign_err = 1'b0;
    err_clr     = 1'b0;
    resync      = 1'b0;
  endtask

  task automatic sample();
    tick();
    #1;
  endtask

  task automatic go_to(input int c);
    do tick(); while (mfc != c);
  endtask

  task automatic fresh();
    tick();
    resync  = 1'b1;
    err_clr = 1'b1;
    sample();
  endtask

  // Watch n cycles; the release is expected only at the first cycle with mfc == target.
  task automatic watch(input int target, input int n, input string req);
    bit done = 1'b0;
    for (int i = 0; i < n; i++) begin
      bit exp;
      sample();
      exp = (mfc == target) && !done;
      check(req, int'(rel_pulse), int'(exp));
      if (exp) done = 1'b1;
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; lane_en = '1; a_arrive = '0; mf_len = MF_W'(MFL);
    rel_ofs = '0; align_all_in = 1'b1; realign_err = 1'b0; err_clr = 1'b0;
    resync = 1'b0; mf_cnt = '0; mf_bnd = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    #1;
    check("R1 rel", int'(rel_pulse), 0);
    check("R1 aligned", int'(dev_aligned), 0);
    check("R1 err", int'(deskew_err), 0);
  endtask

  task automatic t_basic();
    fresh(); rel_ofs = '0; lane_en = 4'hF;
    go_to(2); a_arrive = 4'b0001;
    tick();   a_arrive = 4'b0110;
    sample(); check("R2 partial", int'(dev_aligned), 0);
    a_arrive = 4'b0001;
    sample(); check("R2 repeat ignored", int'(dev_aligned), 0);
    a_arrive = 4'b1001;
    sample(); check("R2 armed", int'(dev_aligned), 1);
    check("R3 no early rel", int'(rel_pulse), 0);
    watch(0, 10, "R3 boundary release");
    check("R3 run aligned", int'(dev_aligned), 1);
  endtask

  task automatic t_offset();
    fresh(); rel_ofs = MF_W'(3);
    go_to(1); a_arrive = 4'hF;
    sample(); check("R4 armed", int'(dev_aligned), 1);
    watch(5, 12, "R4 offset 3 release");
    fresh(); rel_ofs = MF_W'(1);
    go_to(6); a_arrive = 4'hF;
    watch(7, 10, "R4 last legal offset");
    check("R4 no error", int'(deskew_err), 0);
  endtask

  task automatic t_illegal();
    fresh(); rel_ofs = MF_W'(2);
    go_to(6); a_arrive = 4'hF;
    sample();
    check("R5 err", int'(deskew_err), 1);
    check("R5 not aligned", int'(dev_aligned), 0);
    watch(-1, 12, "R11 no release after fail");
  endtask

  task automatic t_spread();
    fresh(); rel_ofs = '0;
    go_to(0); a_arrive = 4'b0001;
    go_to(7); a_arrive = 4'b1110;
    sample();
    check("R6 spread 7 ok", int'(dev_aligned), 1);
    check("R6 spread 7 no err", int'(deskew_err), 0);
    fresh();
    go_to(0); a_arrive = 4'b0001;
    go_to(0); a_arrive = 4'b1110;
    sample();
    check("R6 spread 8 err", int'(deskew_err), 1);
    check("R6 spread 8 not aligned", int'(dev_aligned), 0);
  endtask

  task automatic t_disabled();
    fresh(); rel_ofs = '0; lane_en = 4'b0111;
    go_to(0); a_arrive = 4'b1000;
    repeat (10) tick();
    a_arrive = 4'b0111;
    sample();
    check("R2 disabled lane", int'(dev_aligned), 1);
    check("R2 disabled no window", int'(deskew_err), 0);
    watch(0, 10, "R3 release with lane off");
    lane_en = 4'hF;
  endtask

  task automatic t_gate();
    fresh(); rel_ofs = MF_W'(2); align_all_in = 1'b0;
    go_to(1); a_arrive = 4'hF;
    watch(-1, 8, "R7 held while not all aligned");
    align_all_in = 1'b1;
    watch(6, 10, "R7 next multiframe release");
  endtask

  task automatic t_misalign();
    fresh(); tick(); realign_err = 1'b1;
    sample(); check("R8 ignored in collect", int'(deskew_err), 0);
    rel_ofs = '0;
    go_to(1); a_arrive = 4'hF;
    tick(); realign_err = 1'b1;
    sample();
    check("R8 ignored while armed", int'(deskew_err), 0);
    check("R8 still armed", int'(dev_aligned), 1);
    watch(0, 10, "R3 release after armed");
    tick(); realign_err = 1'b1;
    sample();
    check("R8 err in run", int'(deskew_err), 1);
    check("R8 drop aligned", int'(dev_aligned), 0);
  endtask

  task automatic t_sticky();
    repeat (5) tick();
    #1; check("R9 sticky", int'(deskew_err), 1);
    err_clr = 1'b1;
    sample(); check("R9 cleared", int'(deskew_err), 0);
    fresh(); rel_ofs = MF_W'(7);
    go_to(2); a_arrive = 4'hF; err_clr = 1'b1;
    sample(); check("R9 set beats clear", int'(deskew_err), 1);
  endtask

  task automatic t_resync();
    tick(); resync = 1'b1;
    sample(); check("R10 err kept", int'(deskew_err), 1);
    rel_ofs = '0;
    go_to(1); a_arrive = 4'hF;
    watch(0, 10, "R10 re-armed release");
    check("R10 run", int'(dev_aligned), 1);
    tick(); resync = 1'b1;
    sample(); check("R10 aligned dropped", int'(dev_aligned), 0);
    go_to(3); a_arrive = 4'hF;
    sample(); check("R10 collect again", int'(dev_aligned), 1);
  endtask

  initial begin
    #(4 * 100000);
    n_bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_offset();
    t_illegal();
    t_spread();
    t_disabled();
    t_gate();
    t_misalign();
    t_sticky();
    t_resync();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule